// File: doc/BRIEF.md
# Data-Qualified Hardware Watchpoint Unit

This block observes a processor's load, store and port I/O access stream and raises a debug trap whenever an access touches a programmed watch location. It holds four address comparators. Three of them watch a small naturally aligned span of 1, 2, 4 or 8 bytes. Comparator 0 is the extended one. Any subset of its twelve low address bits can be made don't-care, so it can cover an aligned power-of-two region of up to one 4 KiB page. It can also require that the transferred data equals a programmed value under a per-bit mask.

Each access is presented for one cycle on a strobe together with its address, data, size code and kind. The block never stalls the access stream. It has no ready signal and takes every strobed access in the cycle it is presented. One cycle later it emits a trap pulse and sets sticky status bits for every comparator that hit. Software programs the unit through a simple write port. A write counts only while the current privilege level is 0. A write at any other level changes nothing and raises an error pulse.

Top module: `wp_watch_unit`

## Requirements
- R1: Each comparator i has an 8-bit control field at bits [8i+7:8i] of the control register (select 0): bit 0 enable, bits 2:1 condition, bits 4:3 length code. Condition 01 fires on writes only (kind 01), 11 fires on reads or writes (kinds 00, 01), and 10 fires on I/O reads or writes (kinds 10, 11). Condition 00 never fires. The watch address of comparator i is written at select 8+i.
- R2: The length code n watches 2^n bytes (00=1, 01=2, 10=4, 11=8), aligned to that size, with the low base bits ignored. An access of size code s covers 2^s bytes from its address. It hits when any of its bytes falls in the watched span.
- R3: Bits 11:0 of the address-mask register (select 2) mark address bits of comparator 0 as don't-care. A set bit lets that bit differ, so comparator 0 watches an aligned region of up to 4096 bytes.
- R4: When bit 1 of the mode register (select 1) is set, comparator 0 fires only if every transferred byte lane k (data bits 8k+7:8k, lane 0 at the access address) equals the match register (select 3) in the bits set in the data-mask register (select 4). Lanes beyond the access size are ignored, and the other comparators never compare data.
- R5: I/O-condition comparators fire only while bit 0 of the mode register is set. When that bit is clear, no I/O breakpoint fires.
- R6: A configuration write is accepted only while `priv_lvl` is 0. A write at any other level changes no register and no status bit, and `cfg_err` is high for the single cycle after it.
- R7: A hitting access sets the status bit of every comparator that hit, and `trap` is high for exactly the one cycle after the access.
- R8: Status bits stay set until a write to select 5 clears the bits that are 1 in its data. A new hit sets its bit without clearing the others, and a hit in the same cycle as the clear of its bit leaves that bit set.
- R9: A configuration write affects only accesses in later cycles, never an access presented in the same cycle.
- R10: After reset all comparators are disabled, the mode bits are 0, and `trap`, `hit_status` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_data | input | 64 | Access data, lane 0 at the access address |
| acc_size | input | 2 | Size code, 2^code bytes |
| acc_kind | input | 2 | 00 read, 01 write, 10 I/O read, 11 I/O write |
| priv_lvl | input | 2 | Current privilege level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 64 | Configuration write data |
| trap | output | 1 | Debug trap pulse |
| hit_status | output | 4 | Sticky per-comparator hit bits |
| cfg_err | output | 1 | Rejected-write pulse |

## Verification
The hardest situations to reach from the ports are the collisions within one cycle. The first is a clear of a status bit landing in the same cycle as a new hit on that comparator. The second is a configuration write moving a watch address onto an access presented in that very cycle. The stimulus drives the write port and the access strobe in the same cycle for both. It checks that the hit survives the clear, and that the relocated address catches only the following access. Data qualification is checked with accesses whose untransferred lanes deliberately mismatch the masked match value.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    KIND_RD   = 2'b00,
    KIND_WR   = 2'b01,
    KIND_IORD = 2'b10,
    KIND_IOWR = 2'b11
  } acc_kind_e;

  localparam logic [1:0] COND_WR = 2'b01;
  localparam logic [1:0] COND_IO = 2'b10;
  localparam logic [1:0] COND_RW = 2'b11;

  localparam logic [3:0] SEL_CTRL   = 4'd0;
  localparam logic [3:0] SEL_MODE   = 4'd1;
  localparam logic [3:0] SEL_AMASK  = 4'd2;
  localparam logic [3:0] SEL_DMATCH = 4'd3;
  localparam logic [3:0] SEL_DMASK  = 4'd4;
  localparam logic [3:0] SEL_CLEAR  = 4'd5;
  localparam int         SEL_ADDR0  = 8;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] cond;
    logic       en;
  } cmp_ctrl_t;

  function automatic logic kind_ok(logic [1:0] cond, acc_kind_e kind, logic io_en);
    case (cond)
      COND_WR: return kind == KIND_WR;
      COND_RW: return (kind == KIND_RD) || (kind == KIND_WR);
      COND_IO: return io_en && ((kind == KIND_IORD) || (kind == KIND_IOWR));
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int NUM_CMP   = 4,
  parameter int PAGE_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [3:0]                    cfg_sel,
  input  logic [DW-1:0]                 cfg_wdata,
  input  logic [1:0]                    priv_lvl,
  output logic [NUM_CMP-1:0][AW-1:0]    cmp_addr,
  output cmp_ctrl_t [NUM_CMP-1:0]       cmp_ctrl,
  output logic [PAGE_BITS-1:0]          amask,
  output logic                          io_en,
  output logic                          dcmp_en,
  output logic [DW-1:0]                 dmatch,
  output logic [DW-1:0]                 dmask,
  output logic                          clr_req,
  output logic [NUM_CMP-1:0]            clr_bits,
  output logic                          cfg_err
);
  localparam int CTRL_W = 8;

  logic wr_ok;
  assign wr_ok    = cfg_we && (priv_lvl == 2'd0);
  assign clr_req  = wr_ok && (cfg_sel == SEL_CLEAR);
  assign clr_bits = cfg_wdata[NUM_CMP-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_addr <= '0;
      cmp_ctrl <= '0;
      amask    <= '0;
      io_en    <= 1'b0;
      dcmp_en  <= 1'b0;
      dmatch   <= '0;
      dmask    <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_we && (priv_lvl != 2'd0);
      if (wr_ok) begin
        case (cfg_sel)
          SEL_CTRL: begin
            for (int i = 0; i < NUM_CMP; i++)
              cmp_ctrl[i] <= cfg_wdata[CTRL_W*i +: $bits(cmp_ctrl_t)];
          end
          SEL_MODE: begin
            io_en   <= cfg_wdata[0];
            dcmp_en <= cfg_wdata[1];
          end
          SEL_AMASK:  amask  <= cfg_wdata[PAGE_BITS-1:0];
          SEL_DMATCH: dmatch <= cfg_wdata;
          SEL_DMASK:  dmask  <= cfg_wdata;
          default: begin
            for (int i = 0; i < NUM_CMP; i++)
              if (cfg_sel == 4'(SEL_ADDR0 + i))
                cmp_addr[i] <= cfg_wdata[AW-1:0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/wp_span_cmp.sv
module wp_span_cmp
  import wp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic                 acc_valid,
  input  logic [AW-1:0]        acc_addr,
  input  logic [DW-1:0]        acc_data,
  input  logic [1:0]           acc_size,
  input  acc_kind_e            acc_kind,
  input  logic [AW-1:0]        base,
  input  cmp_ctrl_t            ctrl,
  input  logic [PAGE_BITS-1:0] xmask,
  input  logic                 io_en,
  input  logic                 dcmp_en,
  input  logic [DW-1:0]        dmatch,
  input  logic [DW-1:0]        dmask,
  output logic                 hit
);
  localparam int LANES = DW / 8;

  logic [AW-1:0]    fmask;
  logic [3:0]       nbytes;
  logic [LANES-1:0] addr_hit;
  logic [LANES-1:0] lane_ok;

  assign fmask  = AW'(xmask) | AW'((8'd1 << ctrl.len) - 8'd1);
  assign nbytes = 4'd1 << acc_size;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic          in_acc;
    logic [AW-1:0] byte_addr;
    assign in_acc      = (4'(k) < nbytes);
    assign byte_addr   = acc_addr + AW'(k);
    assign addr_hit[k] = in_acc && (((byte_addr ^ base) & ~fmask) == '0);
    assign lane_ok[k]  = !in_acc ||
                         (((acc_data[8*k +: 8] ^ dmatch[8*k +: 8]) & dmask[8*k +: 8]) == 8'd0);
  end

  assign hit = acc_valid && ctrl.en && kind_ok(ctrl.cond, acc_kind, io_en) &&
               (|addr_hit) && (!dcmp_en || (&lane_ok));
endmodule

// File: rtl/wp_hit_collect.sv
module wp_hit_collect #(
  parameter int NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] hit_vec,
  input  logic               clr_req,
  input  logic [NUM_CMP-1:0] clr_bits,
  output logic               trap,
  output logic [NUM_CMP-1:0] status
);
  logic [NUM_CMP-1:0] clr_mask;
  assign clr_mask = clr_req ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap   <= 1'b0;
      status <= '0;
    end else begin
      trap   <= |hit_vec;
      status <= (status & ~clr_mask) | hit_vec;
    end
  end
endmodule

// File: rtl/wp_watch_unit.sv
module wp_watch_unit
  import wp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int NUM_CMP   = 4,
  parameter int PAGE_BITS = 12,
  parameter int EXT_IDX   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_data,
  input  logic [1:0]         acc_size,
  input  logic [1:0]         acc_kind,
  input  logic [1:0]         priv_lvl,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_sel,
  input  logic [DW-1:0]      cfg_wdata,
  output logic               trap,
  output logic [NUM_CMP-1:0] hit_status,
  output logic               cfg_err
);
  logic [NUM_CMP-1:0][AW-1:0] cmp_addr;
  cmp_ctrl_t [NUM_CMP-1:0]    cmp_ctrl;
  logic [PAGE_BITS-1:0]       amask;
  logic                       io_en_w;
  logic                       dcmp_en;
  logic [DW-1:0]              dmatch;
  logic [DW-1:0]              dmask;
  logic                       clr_req;
  logic [NUM_CMP-1:0]         clr_bits;
  logic [NUM_CMP-1:0]         hit_vec;

  wp_cfg_regs #(.AW(AW), .DW(DW), .NUM_CMP(NUM_CMP), .PAGE_BITS(PAGE_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .priv_lvl(priv_lvl), .cmp_addr(cmp_addr),
    .cmp_ctrl(cmp_ctrl), .amask(amask), .io_en(io_en_w), .dcmp_en(dcmp_en),
    .dmatch(dmatch), .dmask(dmask), .clr_req(clr_req), .clr_bits(clr_bits),
    .cfg_err(cfg_err)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic [PAGE_BITS-1:0] xmask_i;
    logic                 dcmp_i;
    if (i == EXT_IDX) begin : g_ext
      assign xmask_i = amask;
      assign dcmp_i  = dcmp_en;
    end else begin : g_std
      assign xmask_i = '0;
      assign dcmp_i  = 1'b0;
    end
    wp_span_cmp #(.AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS)) u_cmp (
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
      .acc_size(acc_size), .acc_kind(acc_kind_e'(acc_kind)),
      .base(cmp_addr[i]), .ctrl(cmp_ctrl[i]), .xmask(xmask_i),
      .io_en(io_en_w), .dcmp_en(dcmp_i), .dmatch(dmatch), .dmask(dmask),
      .hit(hit_vec[i])
    );
  end

  wp_hit_collect #(.NUM_CMP(NUM_CMP)) u_collect (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .clr_req(clr_req),
    .clr_bits(clr_bits), .trap(trap), .status(hit_status)
  );
endmodule

// File: rtl/wp_watch_unit_chk.sv
module wp_watch_unit_chk
  import wp_pkg::*;
#(
  parameter int DW      = 64,
  parameter int NUM_CMP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [1:0]         acc_kind,
  input logic [1:0]         priv_lvl,
  input logic               cfg_we,
  input logic [3:0]         cfg_sel,
  input logic [DW-1:0]      cfg_wdata,
  input logic               trap,
  input logic [NUM_CMP-1:0] hit_status,
  input logic               cfg_err,
  input logic               io_en
);
  AST_TRAP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(acc_valid)); // R7
  AST_TRAP_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (hit_status != '0)); // R7
  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && acc_kind[1] && !io_en) |-> !trap); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we && (priv_lvl != 2'd0))); // R6
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (priv_lvl != 2'd0)) |=> cfg_err); // R6
  AST_REJECT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (priv_lvl != 2'd0) && !acc_valid) |=> $stable(hit_status)); // R6

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_sticky
    AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hit_status[i]) |->
        $past(cfg_we && (priv_lvl == 2'd0) && (cfg_sel == SEL_CLEAR) && cfg_wdata[i])); // R8
  end
endmodule

bind wp_watch_unit wp_watch_unit_chk #(.DW(DW), .NUM_CMP(NUM_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
  .priv_lvl(priv_lvl), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .trap(trap), .hit_status(hit_status), .cfg_err(cfg_err), .io_en(io_en_w)
);

// File: tb/wp_watch_unit_bench.sv
`timescale 1ns/1ps
module wp_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [63:0] acc_data = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  priv_lvl = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        trap;
  logic [3:0]  hit_status;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wp_watch_unit u_wp_watch_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_size(acc_size), .acc_kind(acc_kind),
    .priv_lvl(priv_lvl), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trap(trap), .hit_status(hit_status), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [1:0]  kind;
    logic [3:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h2010, 2'd2, 2'd0, 4'b0001, 8'd3},  // R3 inside page region
    '{32'h20FE, 2'd2, 2'd1, 4'b1001, 8'd7},  // R7 two comparators hit
    '{32'h2100, 2'd0, 2'd0, 4'b0000, 8'd3},  // R3 just past region
    '{32'h1FFF, 2'd1, 2'd0, 4'b0001, 8'd2},  // R2 straddles region start
    '{32'h3004, 2'd2, 2'd0, 4'b0000, 8'd1},  // R1 read on write-only
    '{32'h3006, 2'd0, 2'd1, 4'b0010, 8'd2},  // R2 inside 4-byte span
    '{32'h3002, 2'd1, 2'd1, 4'b0000, 8'd2},  // R2 ends before span
    '{32'h3003, 2'd1, 2'd1, 4'b0010, 8'd2},  // R2 overlaps span start
    '{32'h0080, 2'd0, 2'd2, 4'b0100, 8'd5},  // R5 I/O read, enabled
    '{32'h0080, 2'd0, 2'd0, 4'b0000, 8'd1},  // R1 memory read on I/O cond
    '{32'h20FC, 2'd2, 2'd1, 4'b1001, 8'd7},  // R7 multi hit
    '{32'h20F0, 2'd3, 2'd1, 4'b0001, 8'd2},  // R2 8-byte access below span
    '{32'h20F4, 2'd3, 2'd0, 4'b1001, 8'd2},  // R2 8-byte access overlap
    '{32'h2005, 2'd0, 2'd3, 4'b0000, 8'd1}   // R1 I/O write on rw cond
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic put_acc(input logic [31:0] a, input logic [63:0] d,
                         input logic [1:0] s, input logic [1:0] k);
    acc_valid = 1'b1; acc_addr = a; acc_data = d; acc_size = s; acc_kind = k;
  endtask

  task automatic put_cfg(input logic [3:0] sel, input logic [63:0] d, input logic [1:0] pl);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; priv_lvl = pl;
  endtask

  task automatic step();
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b0; priv_lvl = 2'd0;
  endtask

  task automatic wcfg(input logic [3:0] sel, input logic [63:0] d);
    put_cfg(sel, d, 2'd0); step();
  endtask

  task automatic access(input logic [31:0] a, input logic [63:0] d,
                        input logic [1:0] s, input logic [1:0] k);
    put_acc(a, d, s, k); step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 trap after reset", 64'(trap), 64'd0);
    check("R10 status after reset", 64'(hit_status), 64'd0);
    check("R10 cfg_err after reset", 64'(cfg_err), 64'd0);
    access(32'h0, 64'h0, 2'd3, 2'd1);
    check("R10 disabled comparators ignore access", 64'(trap), 64'd0);

    wcfg(4'd8,  64'h2000);
    wcfg(4'd9,  64'h3004);
    wcfg(4'd10, 64'h0080);
    wcfg(4'd11, 64'h20F8);
    wcfg(4'd2,  64'h0FF);
    wcfg(4'd1,  64'h1);
    wcfg(4'd0,  64'h1F05_1307);

    for (int v = 0; v < NV; v++) begin
      wcfg(4'd5, 64'hF);
      access(VECS[v].addr, 64'h0, VECS[v].size, VECS[v].kind);
      checks++;
      if (trap !== |VECS[v].exp || hit_status !== VECS[v].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual trap %0b status %b expected trap %0b status %b",
                 VECS[v].req, v, trap, hit_status, |VECS[v].exp, VECS[v].exp);
      end
    end

    // R7 trap lasts one cycle
    wcfg(4'd5, 64'hF);
    access(32'h2010, 64'h0, 2'd0, 2'd0);
    check("R7 trap pulse", 64'(trap), 64'd1);
    step();
    check("R7 trap returns low", 64'(trap), 64'd0);
    check("R8 status held", 64'(hit_status), 64'b0001);

    // R4 data qualification on comparator 0
    wcfg(4'd3, 64'h0000_0011_0000_00AB);
    wcfg(4'd4, 64'h0000_00FF_0000_00FF);
    wcfg(4'd1, 64'h3);
    wcfg(4'd5, 64'hF);
    access(32'h2010, 64'h0000_00FF_0000_00AB, 2'd0, 2'd0);
    check("R4 untransferred lane ignored", 64'(hit_status), 64'b0001);
    wcfg(4'd5, 64'hF);
    access(32'h2010, 64'hAC, 2'd0, 2'd0);
    check("R4 lane mismatch suppresses", 64'(trap), 64'd0);
    access(32'h2010, 64'h0000_0011_0000_00AB, 2'd3, 2'd0);
    check("R4 full match hits", 64'(hit_status), 64'b0001);
    wcfg(4'd5, 64'hF);
    access(32'h2010, 64'h0000_0012_0000_00AB, 2'd3, 2'd0);
    check("R4 upper lane mismatch", 64'(trap), 64'd0);
    access(32'h3004, 64'h0, 2'd0, 2'd1);
    check("R4 standard comparator ignores data", 64'(hit_status), 64'b0010);

    // R5 I/O gating
    wcfg(4'd1, 64'h0);
    wcfg(4'd5, 64'hF);
    access(32'h0080, 64'h0, 2'd0, 2'd2);
    check("R5 I/O disabled no trap", 64'(trap), 64'd0);
    check("R5 I/O disabled no status", 64'(hit_status), 64'd0);

    // R6 privilege
    put_cfg(4'd0, 64'h0, 2'd3); step();
    check("R6 error pulse", 64'(cfg_err), 64'd1);
    access(32'h2010, 64'h0, 2'd0, 2'd0);
    check("R6 rejected write left config", 64'(hit_status), 64'b0001);
    check("R6 error pulse ends", 64'(cfg_err), 64'd0);
    put_cfg(4'd5, 64'hF, 2'd1); step();
    check("R6 rejected clear keeps status", 64'(hit_status), 64'b0001);
    wcfg(4'd5, 64'h0);
    check("R6 level 0 write no error", 64'(cfg_err), 64'd0);

    // R8 sticky accumulate, partial clear, hit beats clear
    access(32'h3004, 64'h0, 2'd0, 2'd1);
    check("R8 accumulate", 64'(hit_status), 64'b0011);
    wcfg(4'd5, 64'h1);
    check("R8 partial clear", 64'(hit_status), 64'b0010);
    put_cfg(4'd5, 64'h2, 2'd0);
    put_acc(32'h3005, 64'h0, 2'd0, 2'd1);
    step();
    check("R8 hit wins over clear", 64'(hit_status), 64'b0010);

    // R9 same-cycle config does not apply
    wcfg(4'd5, 64'hF);
    put_cfg(4'd9, 64'h7000, 2'd0);
    put_acc(32'h7000, 64'h0, 2'd0, 2'd1);
    step();
    check("R9 same-cycle write not applied", 64'(trap), 64'd0);
    access(32'h7000, 64'h0, 2'd0, 2'd1);
    check("R9 next access uses new address", 64'(hit_status), 64'b0010);

    done = 1'b1;
    finish_run();
  end
endmodule